// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block is a self-test controller for a synchronous single-port RAM. After a start pulse it takes over the RAM's enable, write-enable, address and write-data lines. It then runs six pattern phases back to back: two solid fills, two walking-cell passes and two galloping-cell passes. Every read the controller issues is checked against the value the controller expects to find.

The RAM returns read data one cycle after the address. The controller keeps the expected word and the address in a register for that cycle and compares them with the returned word. The first mismatch sets a sticky fail flag and records the failing address. The test still runs through every phase. At the end a done flag rises and stays high until the next start. Every returned read word is also folded into a rotate-and-XOR signature, which the surrounding logic can compare with a known value.

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is held, done_o, fail_o, fail_addr_o, sig_o and mem_en_o are all zero.
- R2: The solid phases first write the pattern word to every address in ascending order, then read every address in ascending order expecting that word. The pattern is all zeros in the first solid phase and all ones in the second.
- R3: The walking-ones phase fills every address with zeros. Then, for each test cell in ascending order, it writes all ones to the cell, reads every other address in ascending order expecting zeros, and writes the cell back to zeros.
- R4: The walking-zeros phase is R3 with every word inverted: the fill is all ones and the test cell is set to all zeros.
- R5: The galloping phases follow R3 (ones) and R4 (zeros), with one change: each read of another address is followed at once by a read of the test cell, which expects the inverted background.
- R6: The phases always run in this order: solid zeros, solid ones, walking ones, walking zeros, galloping ones, galloping zeros. A write cycle has mem_we_o=1 and a read cycle has mem_we_o=0, both with mem_en_o=1.
- R7: A read word is compared in the cycle after its address is presented. Any mismatch sets fail_o, and fail_o stays set until the next start.
- R8: fail_addr_o holds the address of the first mismatching read and does not change on later mismatches.
- R9: The test runs to completion even after a failure. done_o rises exactly T+1 clock edges after the edge that accepts start_i, where T is the number of memory operations. It stays high until the next start.
- R10: start_i is ignored while a test is running.
- R11: An accepted start clears done_o, fail_o, fail_addr_o and sig_o.
- R12: For every returned read word, sig_o is updated to itself rotated left by one bit, XOR the word.
- R13: mem_en_o is low whenever no test is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mem_en_o | output | 1 | RAM enable |
| mem_we_o | output | 1 | RAM write enable (0 = read) |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the address |
| done_o | output | 1 | Test finished |
| fail_o | output | 1 | At least one read mismatched |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| sig_o | output | DATA_W | Read-data signature |

## Verification
The hardest case to reach is a fault that the solid phases cannot see and that appears only after many clean operations. It must then be told apart from an earlier fault at another address. The bench's RAM model can alias writes from one address onto another, which only a walking pass exposes. It can also pin a bit of a word at a fixed value. One run enables both faults, so that a later walking-phase mismatch must leave the first recorded address unchanged. A further run pulses start midway through the test to show the request is dropped.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [2:0] {
    PH_SOLID0, PH_SOLID1, PH_WALK1, PH_WALK0, PH_GALL1, PH_GALL0
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_READ, ST_SET, ST_SCAN, ST_PROBE, ST_REST
  } step_e;
endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              launch_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              chk_vld_o,
  output logic [DATA_W-1:0] chk_exp_o,
  output logic              chk_last_o
);
  localparam logic [ADDR_W-1:0] A_MAX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TWO = ADDR_W'(2);

  step_e             step_q, step_d;
  phase_e            ph_q, ph_d;
  logic [ADDR_W-1:0] a_q, a_d, tc_q, tc_d;
  logic              busy, bg_one, solid, gall, ph_last, scan_last, ph_done;
  logic [DATA_W-1:0] bg_w;
  logic [ADDR_W-1:0] j_first, j_next;

  always_comb begin
    busy      = step_q != ST_IDLE;
    bg_one    = ph_q inside {PH_SOLID1, PH_WALK0, PH_GALL0};
    bg_w      = {DATA_W{bg_one}};
    solid     = ph_q inside {PH_SOLID0, PH_SOLID1};
    gall      = ph_q inside {PH_GALL1, PH_GALL0};
    ph_last   = ph_q == PH_GALL0;
    j_first   = (tc_q == '0) ? A_ONE : '0;
    // skip the test cell while scanning
    j_next    = (a_q + A_ONE == tc_q) ? a_q + A_TWO : a_q + A_ONE;
    scan_last = (a_q == A_MAX) || ((a_q == A_MAX - A_ONE) && (tc_q == A_MAX));
  end

  always_comb begin
    step_d  = step_q;
    ph_d    = ph_q;
    a_d     = a_q;
    tc_d    = tc_q;
    ph_done = 1'b0;
    unique case (step_q)
      ST_IDLE: if (start_i) begin
        step_d = ST_FILL;
        ph_d   = PH_SOLID0;
        a_d    = '0;
        tc_d   = '0;
      end
      ST_FILL: if (a_q == A_MAX) begin
        a_d    = '0;
        tc_d   = '0;
        step_d = solid ? ST_READ : ST_SET;
      end else a_d = a_q + A_ONE;
      ST_READ: if (a_q == A_MAX) ph_done = 1'b1;
               else a_d = a_q + A_ONE;
      ST_SET: begin
        step_d = ST_SCAN;
        a_d    = j_first;
      end
      ST_SCAN: if (gall) step_d = ST_PROBE;
               else if (scan_last) step_d = ST_REST;
               else a_d = j_next;
      ST_PROBE: if (scan_last) step_d = ST_REST;
                else begin
                  step_d = ST_SCAN;
                  a_d    = j_next;
                end
      ST_REST: if (tc_q == A_MAX) ph_done = 1'b1;
               else begin
                 tc_d   = tc_q + A_ONE;
                 step_d = ST_SET;
               end
      default: step_d = ST_IDLE;
    endcase
    if (ph_done) begin
      if (ph_last) step_d = ST_IDLE;
      else begin
        ph_d   = phase_e'(ph_q + 3'd1);
        step_d = ST_FILL;
        a_d    = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      ph_q   <= PH_SOLID0;
      a_q    <= '0;
      tc_q   <= '0;
    end else begin
      step_q <= step_d;
      ph_q   <= ph_d;
      a_q    <= a_d;
      tc_q   <= tc_d;
    end
  end

  always_comb begin
    launch_o    = (step_q == ST_IDLE) && start_i;
    mem_en_o    = busy;
    mem_we_o    = step_q inside {ST_FILL, ST_SET, ST_REST};
    mem_addr_o  = (step_q inside {ST_SET, ST_PROBE, ST_REST}) ? tc_q : a_q;
    mem_wdata_o = (step_q == ST_SET) ? ~bg_w : bg_w;
    chk_vld_o   = step_q inside {ST_READ, ST_SCAN, ST_PROBE};
    chk_exp_o   = (step_q == ST_PROBE) ? ~bg_w : bg_w;
    chk_last_o  = (step_q == ST_REST) && (tc_q == A_MAX) && ph_last;
  end

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i && !chk_last_o) |=> (busy && !launch_o));

  p_we_in_run_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_vld_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              done_o
);
  logic              vld_q, last_q, fail_q, done_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q, fail_addr_q;
  logic              miss;

  // expected word lines up with the RAM's one-cycle read latency
  assign miss = vld_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q       <= 1'b0;
      last_q      <= 1'b0;
      exp_q       <= '0;
      addr_q      <= '0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      done_q      <= 1'b0;
    end else if (clr_i) begin
      vld_q       <= 1'b0;
      last_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      done_q      <= 1'b0;
    end else begin
      vld_q  <= vld_i;
      last_q <= last_i;
      exp_q  <= exp_i;
      addr_q <= addr_i;
      if (miss && !fail_q) begin
        fail_q      <= 1'b1;
        fail_addr_q <= addr_q;
      end
      if (last_q) done_q <= 1'b1;
    end
  end

  assign rd_vld_o    = vld_q;
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign done_o      = done_q;

  p_fail_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !clr_i) |=> fail_o);

  p_fail_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(vld_q));

  p_first_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !clr_i) |=> $stable(fail_addr_o));

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);

  p_start_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!fail_o && !done_o));
endmodule

// File: rtl/mbist_sig.sv
module mbist_sig #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] sig_o
);
  logic [DATA_W-1:0] sig_q, rot;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rot
    localparam int SRC = (i + DATA_W - 1) % DATA_W;
    assign rot[i] = sig_q[SRC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= '0;
    else if (clr_i)  sig_q <= '0;
    else if (vld_i)  sig_q <= rot ^ rdata_i;
  end

  assign sig_o = sig_q;

  p_sig_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !clr_i) |=> $stable(sig_o));
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] sig_o
);
  logic              launch, chk_vld, chk_last, rd_vld;
  logic [DATA_W-1:0] chk_exp;

  mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .launch_o    (launch),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .chk_vld_o   (chk_vld),
    .chk_exp_o   (chk_exp),
    .chk_last_o  (chk_last)
  );

  mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (launch),
    .vld_i       (chk_vld),
    .exp_i       (chk_exp),
    .addr_i      (mem_addr_o),
    .last_i      (chk_last),
    .rdata_i     (mem_rdata_i),
    .rd_vld_o    (rd_vld),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .done_o      (done_o)
  );

  mbist_sig #(.DATA_W(DATA_W)) u_sig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (launch),
    .vld_i   (rd_vld),
    .rdata_i (mem_rdata_i),
    .sig_o   (sig_o)
  );
endmodule

// File: tb/tb_mbist_ctrl.sv
module tb_mbist_ctrl;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int CLK_P = 10;

  typedef struct {
    bit          we;
    int          addr;
    logic [DW-1:0] data;
    string       req;
  } op_t;

  logic          clk = 0, rst_n = 0, start = 0;
  logic          mem_en, mem_we, done, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, sig;

  int checks = 0, failures = 0;
  op_t sb[$];
  logic [DW-1:0] exp_sig;
  bit mon_on = 0;

  // fault controls for the RAM model
  bit stuck_on = 0; int stuck_a = 0; int stuck_b = 0; bit stuck_v = 0;
  bit alias_on = 0; int alias_src = 9; int alias_dst = 3;
  logic [DW-1:0] ram [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr), .sig_o(sig)
  );

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        ram[mem_addr] <= mem_wdata;
        if (alias_on && int'(mem_addr) == alias_src) ram[alias_dst] <= mem_wdata;
      end else begin
        logic [DW-1:0] v;
        v = ram[mem_addr];
        if (stuck_on && int'(mem_addr) == stuck_a) v[stuck_b] = stuck_v;
        mem_rdata <= v;
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(bit we, int a, logic [DW-1:0] d, string r);
    op_t o;
    o.we = we; o.addr = a; o.data = d; o.req = r;
    sb.push_back(o);
  endtask

  // expected operation stream, phase order per R6
  task automatic gen_ops();
    logic [DW-1:0] bg;
    string r;
    sb.delete();
    for (int p = 0; p < 6; p++) begin
      bg = (p % 2 == 1) ? '1 : '0;
      r  = (p < 2) ? "R2" : (p == 2) ? "R3" : (p == 3) ? "R4" : "R5";
      for (int a = 0; a < DEPTH; a++) push(1, a, bg, r);
      if (p < 2) begin
        for (int a = 0; a < DEPTH; a++) push(0, a, bg, r);
      end else begin
        for (int t = 0; t < DEPTH; t++) begin
          push(1, t, ~bg, r);
          for (int j = 0; j < DEPTH; j++) begin
            if (j != t) begin
              push(0, j, bg, r);
              if (p >= 4) push(0, t, ~bg, r);
            end
          end
          push(1, t, bg, r);
        end
      end
    end
    exp_sig = '0;
    foreach (sb[i]) if (!sb[i].we) exp_sig = {exp_sig[DW-2:0], exp_sig[DW-1]} ^ sb[i].data;
  endtask

  // monitor: pop one expected op for each enabled RAM cycle
  always @(negedge clk) begin
    if (mon_on && mem_en) begin
      op_t e;
      if (sb.size() == 0) begin
        check(0, "R6", "operation beyond expected stream", {31'd0, mem_we}, 0);
      end else begin
        e = sb.pop_front();
        check(mem_we == e.we, e.req, "write enable", {31'd0, mem_we}, {31'd0, e.we});
        check(int'(mem_addr) == e.addr, e.req, "address", 32'(mem_addr), 32'(e.addr));
        if (e.we) check(mem_wdata == e.data, e.req, "write data", 32'(mem_wdata), 32'(e.data));
      end
    end
  end

  task automatic run(bit clean, bit mid_start, bit exp_fail, int exp_addr);
    int t_ops, n;
    logic [AW-1:0] fa;
    gen_ops();
    t_ops = sb.size();
    mon_on = 1;
    @(negedge clk) start = 1;
    @(posedge clk);
    @(negedge clk) start = 0;
    check(!fail && !done && sig == '0, "R11", "clear on start {fail,done,sig}",
          {22'd0, fail, done, sig}, 0);
    n = 0;
    while (!done && n < 5000) begin
      start = (mid_start && (n == 100 || n == 101));
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 0;
    check(n == t_ops + 1, mid_start ? "R10" : "R9", "edges from start to done", n, t_ops + 1);
    check(fail == exp_fail, "R7", "fail flag", {31'd0, fail}, {31'd0, exp_fail});
    if (exp_fail) check(int'(fail_addr) == exp_addr, "R8", "first fail address", 32'(fail_addr), exp_addr);
    if (clean) check(sig == exp_sig, "R12", "signature", 32'(sig), 32'(exp_sig));
    check(sb.size() == 0, "R6", "ops left in scoreboard", sb.size(), 0);
    fa = fail_addr;
    repeat (4) @(negedge clk);
    check(done, "R9", "done held", {31'd0, done}, 1);
    check(!mem_en, "R13", "RAM idle after test", {31'd0, mem_en}, 0);
    check(fail == exp_fail && fail_addr == fa, "R8", "fail state held", 32'(fail_addr), 32'(fa));
    mon_on = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !fail && fail_addr == '0 && sig == '0 && !mem_en, "R1", "reset outputs",
          {17'd0, done, fail, mem_en, fail_addr, sig}, 0);
    rst_n = 1;
    @(negedge clk);
    // clean pass
    run(1, 0, 0, 0);
    // start pulses while running are dropped (R10)
    run(1, 1, 0, 0);
    // bit 2 of address 5 pinned high: seen by the solid-zero reads (R7)
    stuck_on = 1; stuck_a = 5; stuck_b = 2; stuck_v = 1;
    run(0, 0, 1, 5);
    // address 12 bit 0 pinned low plus write alias 9->3: first miss stays 12 (R8)
    stuck_a = 12; stuck_b = 0; stuck_v = 0; alias_on = 1;
    run(0, 0, 1, 12);
    // alias alone: only the walking pass exposes it, at address 3 (R3)
    stuck_on = 0;
    run(0, 0, 1, 3);
    // fault-free again: start clears the earlier failure (R11)
    alias_on = 0;
    run(1, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule